// File: doc/BRIEF.md
# Wavefront Inclusive Prefix-Scan Sequencer

This block computes an inclusive prefix scan across a 64-lane wavefront. Each active lane k ends with the combination of the inputs of every active lane from 0 up to k. The combination is one of add, signed min, signed max, float min or float max, picked by an operation code. Lanes are grouped into four rows of sixteen, and each row is split into four banks of four lanes. The scan runs as a fixed schedule of seven swizzle-and-combine steps on an internal accumulator vector.

The first three steps take the captured input shifted right within its row by 1, 2 and 3 lanes. The next two take the accumulator shifted right by 4 and by 8, restricted by bank enables. The last two broadcast a row's last lane into later rows, restricted by row enables. A lane whose source falls outside its row, or whose bank or row is disabled, keeps its accumulator value. Two idle cycles come before each step that reads the accumulator through the swizzle.

A start pulse captures the input vector, the execute mask and the operation. The result stays on the output until the next accepted start, and a one-cycle done pulse marks completion.

Top module: `wave_scan_seq`

## Requirements
- R1: After reset, done is low and every lane of result_vec is zero.
- R2: A start accepted at a clock edge produces a done pulse that is visible in the cycle after the 15th following edge. The 15 cycles are three single steps, then four steps each preceded by two idle cycles.
- R3: For each active lane k, result_vec lane k (bits k*32 +: 32) equals the left-to-right fold of the selected operation over the inputs of active lanes 0..k. This holds across the row boundaries at lanes 15/16, 31/32 and 47/48. Add wraps modulo 2^32.
- R4: A lane whose exec_mask bit is 0 returns its own captured input unchanged, and it has no effect on the result of any other lane.
- R5: op_sel encodings are 0 = add, 1 = signed min, 2 = signed max, 3 = float min and 4 = float max; codes 5 to 7 act as add. Float ordering treats any negative value as below any non-negative one, with -0 below +0. Non-negative values order by magnitude, and negative values order by reversed magnitude.
- R6: A start asserted while a scan is in progress is ignored. The running scan's result and done timing are unchanged, and no extra done pulse appears.
- R7: done is high for exactly one cycle per scan. After it, result_vec holds its value until the next accepted start.
- R8: Changes to in_vec, exec_mask and op_sel after the start edge have no effect on the scan in progress.
- R9: With an all-zero exec_mask, every lane of the result equals its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| op_sel | input | 3 | Operation code (see R5) |
| exec_mask | input | 64 | Per-lane active bit |
| in_vec | input | 2048 | Input vector, lane k at bits k*32 +: 32 |
| result_vec | output | 2048 | Scanned vector, lane k at bits k*32 +: 32 |
| done | output | 1 | One-cycle completion pulse |

## Verification
An all-active add of the values 1 to 64 shows that the three short shifts, the two masked long shifts and the two broadcasts each cover the lanes they should. Random values under random masks for every operation code show that inactive lanes take the identity, because a zero identity would corrupt min and max. Sparse masks that leave a single active lane on either side of a row boundary separate correct broadcast sources from an off-by-one row. An all-inactive mask, a start issued mid-scan and input changes after the start edge confirm that the captured state alone drives the result.

// File: rtl/wave_scan_seq.sv
`timescale 1ns/1ps
module wave_scan_seq #(
  parameter int LANES = 64,
  parameter int ROW   = 16,
  parameter int BANK  = 4,
  parameter int W     = 32,
  parameter int EXP   = 8,
  parameter int GAP   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         op_sel,
  input  logic [LANES-1:0]   exec_mask,
  input  logic [LANES*W-1:0] in_vec,
  output logic [LANES*W-1:0] result_vec,
  output logic               done
);
  localparam int GW = (GAP < 1) ? 1 : $clog2(GAP + 1);
  localparam logic [W-1:0] POS_INF = {1'b0, {EXP{1'b1}}, {(W-1-EXP){1'b0}}};
  localparam logic [W-1:0] NEG_INF = {1'b1, {EXP{1'b1}}, {(W-1-EXP){1'b0}}};
  localparam logic [W-1:0] S_TOP   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_BOT   = {1'b1, {(W-1){1'b0}}};
  localparam logic [3:0]   ROWEN6  = 4'hA;
  localparam logic [3:0]   ROWEN7  = 4'hC;

  function automatic logic [W-1:0] ident(input logic [2:0] op);
    case (op)
      3'd1:    return S_TOP;
      3'd2:    return S_BOT;
      3'd3:    return POS_INF;
      3'd4:    return NEG_INF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] fkey(input logic [W-1:0] x);
    return x[W-1] ? ~x : {1'b1, x[W-2:0]};
  endfunction

  function automatic logic [W-1:0] combine(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (op)
      3'd1:    return ($signed(a) < $signed(b)) ? a : b;
      3'd2:    return ($signed(a) > $signed(b)) ? a : b;
      3'd3:    return (fkey(a) < fkey(b)) ? a : b;
      3'd4:    return (fkey(a) > fkey(b)) ? a : b;
      default: return a + b;
    endcase
  endfunction

  function automatic int shamt(input int k);
    return (k <= 3) ? k : ((k == 4) ? 4 : 8);
  endfunction

  function automatic logic [3:0] bank_en(input int k);
    return (k == 4) ? 4'hE : ((k == 5) ? 4'hC : 4'hF);
  endfunction

  logic             busy;
  logic [2:0]       step;
  logic [GW-1:0]    gap;
  logic [2:0]       op_q;
  logic [LANES-1:0] mask_q;
  logic [W-1:0]     raw [LANES];
  logic [W-1:0]     acc [LANES];
  logic [W-1:0]     inm [LANES];
  logic [W-1:0]     nxt [LANES];
  logic [W-1:0]     src [LANES][1:7];
  logic             ok  [LANES][1:7];
  logic             fire;

  assign fire = busy && (gap == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int P = l % ROW;
    localparam int R = l / ROW;
    localparam int B = P / BANK;

    assign inm[l] = mask_q[l] ? raw[l] : ident(op_q);

    for (genvar k = 1; k <= 5; k++) begin : g_shift
      localparam int N = shamt(k);
      localparam logic [3:0] BE = bank_en(k);
      if (P >= N) begin : g_in
        if (k <= 3) begin : g_from_input
          assign src[l][k] = inm[l-N];
        end else begin : g_from_acc
          assign src[l][k] = acc[l-N];
        end
        assign ok[l][k] = BE[B];
      end else begin : g_out
        assign src[l][k] = '0;
        assign ok[l][k]  = 1'b0;
      end
    end

    if (R > 0 && ROWEN6[R]) begin : g_b15
      assign src[l][6] = acc[R*ROW-1];
      assign ok[l][6]  = 1'b1;
    end else begin : g_nb15
      assign src[l][6] = '0;
      assign ok[l][6]  = 1'b0;
    end

    if (R >= 2 && ROWEN7[R]) begin : g_b31
      assign src[l][7] = acc[2*ROW-1];
      assign ok[l][7]  = 1'b1;
    end else begin : g_nb31
      assign src[l][7] = '0;
      assign ok[l][7]  = 1'b0;
    end

    assign nxt[l] = (fire && ok[l][step]) ? combine(op_q, src[l][step], acc[l]) : acc[l];
    assign result_vec[l*W +: W] = mask_q[l] ? acc[l] : raw[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= 3'd1;
      gap    <= '0;
      done   <= 1'b0;
      op_q   <= '0;
      mask_q <= '0;
      for (int l = 0; l < LANES; l++) begin
        raw[l] <= '0;
        acc[l] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        step   <= 3'd1;
        gap    <= '0;
        op_q   <= op_sel;
        mask_q <= exec_mask;
        for (int l = 0; l < LANES; l++) begin
          raw[l] <= in_vec[l*W +: W];
          acc[l] <= exec_mask[l] ? in_vec[l*W +: W] : ident(op_sel);
        end
      end else if (busy) begin
        for (int l = 0; l < LANES; l++) acc[l] <= nxt[l];
        if (gap != '0) begin
          gap <= gap - GW'(1);
        end else if (step == 3'd7) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 3'd1;
          gap  <= (step >= 3'd3) ? GW'(GAP) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/wave_scan_seq_chk.sv
`timescale 1ns/1ps
module wave_scan_seq_chk #(
  parameter int LANES = 64,
  parameter int W     = 32,
  parameter int GAP   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [LANES-1:0]   exec_mask,
  input logic [LANES*W-1:0] in_vec,
  input logic [LANES*W-1:0] result_vec,
  input logic               done
);
  localparam int LAT = 3 + 4 * (GAP + 1);
  localparam int CW  = $clog2(LAT + 1);

  logic [CW-1:0]      cnt;
  logic [LANES*W-1:0] in_cap;
  logic [LANES*W-1:0] idle_bits;
  logic [LANES-1:0]   mask_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      in_cap   <= '0;
      mask_cap <= '0;
    end else if (start && cnt == '0) begin
      cnt      <= CW'(LAT);
      in_cap   <= in_vec;
      mask_cap <= exec_mask;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_bits
    assign idle_bits[l*W +: W] = {W{~mask_cap[l]}};
  end

  a_r2_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CW'(1) |=> done);
  a_r2_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cnt) == CW'(1));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == '0 && !$past(start)) |-> $stable(result_vec));
  a_r4_inactive_pass: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result_vec ^ in_cap) & idle_bits) == '0);
endmodule

bind wave_scan_seq wave_scan_seq_chk #(.LANES(LANES), .W(W), .GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .exec_mask(exec_mask),
  .in_vec(in_vec), .result_vec(result_vec), .done(done));

// File: tb/wave_scan_seq_tb_top.sv
`timescale 1ns/1ps
module wave_scan_seq_tb_top;
  localparam int LANES = 64;
  localparam int W     = 32;
  typedef logic [LANES*W-1:0] vec_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [2:0]       op_sel;
  logic [LANES-1:0] exec_mask;
  vec_t             in_vec;
  vec_t             result_vec;
  logic             done;

  always #2 clk = ~clk;

  wave_scan_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .exec_mask(exec_mask), .in_vec(in_vec), .result_vec(result_vec), .done(done));

  int checks = 0, fails = 0, cyc = 0;
  bit prev_done = 0;
  vec_t exp_q[$];
  logic [LANES-1:0] msk_q[$];
  int due_q[$];
  string tag_q[$];
  vec_t last_exp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit flt_lt(logic [31:0] a, logic [31:0] b);
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction

  function automatic logic [31:0] ref_op(logic [2:0] op, logic [31:0] acc, logic [31:0] x);
    case (op)
      3'd1: return ($signed(x) < $signed(acc)) ? x : acc;
      3'd2: return ($signed(x) > $signed(acc)) ? x : acc;
      3'd3: return flt_lt(x, acc) ? x : acc;
      3'd4: return flt_lt(acc, x) ? x : acc;
      default: return acc + x;
    endcase
  endfunction

  function automatic vec_t ref_scan(logic [2:0] op, logic [LANES-1:0] m, vec_t x);
    vec_t r;
    logic [31:0] acc;
    bit seen = 0;
    acc = '0;
    for (int k = 0; k < LANES; k++) begin
      if (m[k]) begin
        acc = seen ? ref_op(op, acc, x[k*W +: W]) : x[k*W +: W];
        seen = 1;
        r[k*W +: W] = acc;
      end else begin
        r[k*W +: W] = x[k*W +: W];
      end
    end
    return r;
  endfunction

  function automatic vec_t rnd_vec(bit flt);
    vec_t v;
    for (int k = 0; k < LANES; k++) begin
      if (flt) v[k*W +: W] = {1'($urandom), 8'($urandom_range(254, 0)), 23'($urandom)};
      else     v[k*W +: W] = $urandom;
    end
    return v;
  endfunction

  function automatic logic [LANES-1:0] rnd_mask();
    return {$urandom, $urandom} & {$urandom, $urandom} | {$urandom, $urandom} & 64'h0F0F_F0F0_00FF_FF00;
  endfunction

  // driver: caller stands at a negedge; returns at the negedge where done is expected
  task automatic scan(logic [2:0] op, logic [LANES-1:0] m, vec_t x, string tag, int intrude = 0);
    start = 1; op_sel = op; exec_mask = m; in_vec = x;
    exp_q.push_back(ref_scan(op, m, x));
    msk_q.push_back(m);
    due_q.push_back(cyc + 16);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 0;
    // R8: scramble the inputs once the scan has captured them
    in_vec = rnd_vec(0); exec_mask = ~m; op_sel = op ^ 3'd1;
    for (int c = 1; c < 16; c++) begin
      if (intrude != 0 && c == intrude) start = 1;   // R6 intrusion
      else start = 0;
      @(negedge clk);
    end
    start = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        checks++;
        if (done) begin fails++; $display("FAIL R7 done high two cycles: actual 1 expected 0"); end
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 unexpected done: actual 1 expected 0");
        end else begin
          vec_t e;
          logic [LANES-1:0] m;
          int due;
          string tag;
          int bad;
          e = exp_q.pop_front(); m = msk_q.pop_front(); due = due_q.pop_front(); tag = tag_q.pop_front();
          last_exp = e;
          checks++;
          if (cyc != due) begin
            fails++;
            $display("FAIL R2 done cycle (%s): actual %0d expected %0d", tag, cyc, due);
          end
          checks++;
          bad = -1;
          for (int k = LANES-1; k >= 0; k--)
            if (result_vec[k*W +: W] !== e[k*W +: W]) bad = k;
          if (bad >= 0) begin
            fails++;
            $display("FAIL %s lane %0d (%s): actual %h expected %h", m[bad] ? "R3" : "R4",
                     bad, tag, result_vec[bad*W +: W], e[bad*W +: W]);
          end
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    logic [LANES-1:0] m;
    rst_n = 0; start = 0; op_sel = 0; exec_mask = '0; in_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || result_vec !== '0) begin
      fails++;
      $display("FAIL R1 reset state: actual done %b expected 0", done);
    end

    // R3: add of 1..64, every lane active
    for (int k = 0; k < LANES; k++) v[k*W +: W] = 32'(k + 1);
    scan(3'd0, '1, v, "R3 add ramp");

    // R5/R3/R4: each operation with random masks
    for (int op = 0; op < 5; op++)
      for (int r = 0; r < 3; r++)
        scan(3'(op), rnd_mask(), rnd_vec(op >= 3), "R5 random op");

    // R5: spare codes act as add
    scan(3'd6, rnd_mask(), rnd_vec(0), "R5 code 6");
    scan(3'd7, '1, rnd_vec(0), "R5 code 7");

    // R9: nothing active
    scan(3'd1, '0, rnd_vec(0), "R9 all inactive");

    // R3: single active lane past a row edge, and sparse lanes across rows
    scan(3'd2, 64'h1 << 16, rnd_vec(0), "R3 lane 16 only");
    m = '0; m[15] = 1; m[47] = 1; m[48] = 1; m[31] = 1;
    scan(3'd2, m, rnd_vec(0), "R3 row edges max");
    scan(3'd3, m, rnd_vec(1), "R3 row edges fmin");

    // R5: signed zero ordering for float min
    v = rnd_vec(1); v[0 +: W] = 32'h0000_0000; v[W +: W] = 32'h8000_0000;
    scan(3'd3, 64'h3, v, "R5 signed zero");

    // R6: start pulses while busy
    scan(3'd1, rnd_mask(), rnd_vec(0), "R6 start mid-scan", 5);
    scan(3'd0, rnd_mask(), rnd_vec(0), "R6 start before final step", 14);

    // R7: result holds after done
    repeat (6) @(negedge clk);
    checks++;
    if (result_vec !== last_exp) begin
      fails++;
      $display("FAIL R7 result hold: actual %h expected %h", result_vec[31:0], last_exp[31:0]);
    end
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing done: actual %0d pending expected 0", exp_q.size());
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule